// File: doc/BRIEF.md
# Three-wire serial word memory, read side

This block is the slave end of a three-wire clocked serial memory link. A host raises the select line, toggles the serial clock and shifts a command in on the data input. The command begins with a high start bit, then a two-bit opcode, then a word address sent most significant bit first. When the opcode asks for a read, the block answers on its data output. It sends one low lead bit and then the addressed 16-bit word, most significant bit first. It keeps streaming the following words for as long as the host keeps clocking with select held high. Other opcodes are accepted and then ignored.

All three serial inputs pass through synchronizers into the system clock domain. The serial clock's rising edge is found there. The output is a data bit plus an output enable, and a low enable stands for high impedance. A separate synchronous write port fills the word array.

Top module: `mw_read_slave`

## Requirements
- R1: While the select input is low, serial clock and data input have no effect. The output enable is low no later than three system clocks after select falls.
- R2: After select rises, serial clock rising edges that sample the data input low are discarded. The first high sample is taken as the start bit.
- R3: The two bits after the start bit are the opcode, and 1 then 0 (first bit sent first) means read. On the serial clock rising edge that samples the last address bit, the output enable rises and the data bit is 0.
- R4: On each later serial clock rising edge, one data bit of the addressed word appears, bit 15 first and bit 0 last. The output changes on no other edge.
- R5: After bit 0 of a word, the next serial clock rising edge gives bit 15 of the word at the next address, with no new command.
- R6: Streaming past the highest address (2^ADDR_W - 1) continues at address 0.
- R7: Opcodes 00, 01 and 11 are consumed together with their address field. After that the output enable stays low until select falls.
- R8: Dropping select in the middle of a command or a stream releases the output. The next command after select rises again is decoded from scratch.
- R9: A cycle with the load enable high writes the load data into the word at the load address, and later reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in |
| ld_en | input | 1 | Array load enable |
| ld_addr | input | ADDR_W | Array load address |
| ld_data | input | WORD_W | Array load data |
| do_out | output | 1 | Serial data out (0 when not enabled) |
| do_oe | output | 1 | Output enable; low means high impedance |

## Verification
A serial clock rise on the pin reaches the outputs on the third system clock edge after it: two synchronizer stages, then the state register. The bench holds each serial clock level for four system clocks and samples the outputs at the falling clock edge just before the next level change, so every result is already settled. A fall of the select line releases the output by the third edge, and the bench waits six clocks before it checks the release. The bench sweeps every start address, lead-in lengths of zero to three dummy clocks, every non-read opcode, a full wrap of the array and an aborted stream.

// File: rtl/mw_read_slave.sv
module mw_read_slave #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              sk,
  input  logic              di,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  output logic              do_out,
  output logic              do_oe
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int CMD_BITS = ADDR_W + 2;
  localparam int CW       = $clog2(CMD_BITS) + 1;
  localparam int BW       = $clog2(WORD_W);
  localparam logic [CW-1:0] CMD_LAST = CW'(CMD_BITS - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(WORD_W - 1);

  typedef enum logic [1:0] {S_WAIT, S_CMD, S_DATA, S_SKIP} state_t;

  logic [SYNC-1:0] cs_q, sk_q, di_q;
  logic            sk_d;
  logic            cs_s, sk_s, di_s, sk_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q <= '0;
      sk_q <= '0;
      di_q <= '0;
      sk_d <= 1'b0;
    end else begin
      cs_q <= {cs_q[SYNC-2:0], cs};
      sk_q <= {sk_q[SYNC-2:0], sk};
      di_q <= {di_q[SYNC-2:0], di};
      sk_d <= sk_s;
    end
  end

  assign cs_s    = cs_q[SYNC-1];
  assign sk_s    = sk_q[SYNC-1];
  assign di_s    = di_q[SYNC-1];
  assign sk_rise = sk_s & ~sk_d;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk)
    if (ld_en) mem[ld_addr] <= ld_data;

  state_t              state;
  logic [CW-1:0]       cnt;
  logic [CMD_BITS-2:0] sreg;
  logic [ADDR_W-1:0]   addr;
  logic [BW-1:0]       bitn;
  logic [WORD_W-1:0]   shreg;
  logic                dbit, oe_r;
  logic [CMD_BITS-1:0] cmd_full;
  logic [ADDR_W-1:0]   addr_nxt;

  assign cmd_full = {sreg, di_s};
  assign addr_nxt = addr + ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || !cs_s) begin
      state <= S_WAIT;
      cnt   <= '0;
      sreg  <= '0;
      addr  <= '0;
      bitn  <= '0;
      shreg <= '0;
      dbit  <= 1'b0;
      oe_r  <= 1'b0;
    end else if (sk_rise) begin
      unique case (state)
        S_WAIT: if (di_s) begin
          state <= S_CMD;
          cnt   <= '0;
        end
        S_CMD: begin
          sreg <= cmd_full[CMD_BITS-2:0];
          cnt  <= cnt + CW'(1);
          if (cnt == CMD_LAST) begin
            if (cmd_full[CMD_BITS-1:CMD_BITS-2] == 2'b10) begin
              state <= S_DATA;
              addr  <= cmd_full[ADDR_W-1:0];
              shreg <= mem[cmd_full[ADDR_W-1:0]];
              bitn  <= '0;
              dbit  <= 1'b0;
              oe_r  <= 1'b1;
            end else begin
              state <= S_SKIP;
            end
          end
        end
        S_DATA: begin
          dbit <= shreg[WORD_W-1];
          if (bitn == BIT_LAST) begin
            bitn  <= '0;
            addr  <= addr_nxt;
            shreg <= mem[addr_nxt];
          end else begin
            bitn  <= bitn + BW'(1);
            shreg <= {shreg[WORD_W-2:0], 1'b0};
          end
        end
        S_SKIP: ;
        default: state <= S_WAIT;
      endcase
    end
  end

  assign do_oe  = oe_r & cs_s;
  assign do_out = dbit & do_oe;
endmodule

module mw_read_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic sk_rise,
  input logic do_out,
  input logic do_oe
);
  logic [1:0] cs_low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cs_low_cnt <= '0;
    else if (cs)            cs_low_cnt <= '0;
    else if (cs_low_cnt != 2'd3) cs_low_cnt <= cs_low_cnt + 2'd1;
  end

  AST_RELEASE_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) (cs_low_cnt == 2'd3) |-> !do_oe); // R1
  AST_OE_RISES_ON_SK_EDGE: assert property (@(posedge clk) disable iff (!rst_n) $rose(do_oe) |-> $past(sk_rise)); // R3
  AST_LEAD_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(do_oe) |-> !do_out); // R3
  AST_DATA_HOLDS_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rst_n) (do_oe && $past(do_oe) && !$past(sk_rise)) |-> $stable(do_out)); // R4
  AST_DATA_KNOWN: assert property (@(posedge clk) disable iff (!rst_n) do_oe |-> !$isunknown(do_out)); // R4
endmodule

bind mw_read_slave mw_read_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .sk_rise(sk_rise),
  .do_out(do_out), .do_oe(do_oe)
);

// File: tb/mw_read_slave_tb.sv
module mw_read_slave_tb;
  localparam int AW = 6;
  localparam int WW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [WW-1:0] ld_data = '0;
  logic do_out, do_oe;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [WW-1:0] model [DEPTH];

  always #2.5 clk = ~clk;

  mw_read_slave #(.ADDR_W(AW), .WORD_W(WW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .do_out(do_out), .do_oe(do_oe)
  );

  function automatic logic [WW-1:0] pattern(input int i);
    return WW'((i * 16'h1357) ^ 16'hA5C3 ^ (i << 9));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input int a, input logic [WW-1:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = AW'(a); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
    model[a] = d;
  endtask

  task automatic clk_bit(input logic b);
    di = b;
    repeat (4) @(negedge clk);
    sk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic sk_low;
    sk = 1'b0;
  endtask

  task automatic select;
    sk = 1'b0; di = 1'b0;
    cs = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic deselect;
    sk = 1'b0;
    cs = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [1:0] op, input int a, input int dummies);
    for (int k = 0; k < dummies; k++) begin clk_bit(1'b0); sk_low(); end
    clk_bit(1'b1); sk_low();
    clk_bit(op[1]); sk_low();
    clk_bit(op[0]); sk_low();
    for (int k = AW - 1; k >= 0; k--) begin
      clk_bit(a[k]);
      if (k > 0) sk_low();
    end
  endtask

  task automatic read_words(input int a, input int nwords, input int dummies, input string req);
    logic [WW-1:0] got;
    select();
    send_cmd(2'b10, a, dummies);
    chk(do_oe === 1'b1 && do_out === 1'b0, "R3 lead bit", {do_oe, do_out}, 2'b10);
    sk_low();
    for (int w = 0; w < nwords; w++) begin
      for (int b = 0; b < WW; b++) begin
        clk_bit(1'b0);
        got[WW-1-b] = do_out;
        sk_low();
      end
      chk(got === model[(a + w) % DEPTH], req, got, model[(a + w) % DEPTH]);
    end
    deselect();
    chk(do_oe === 1'b0, "R1 release after select low", do_oe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(do_oe === 1'b0, "R1 reset state", do_oe, 0);

    // R9: fill the array through the load port
    for (int i = 0; i < DEPTH; i++) load(i, pattern(i));

    // R4 R2: every start address, lead-in of 0..3 dummy clocks
    for (int a = 0; a < DEPTH; a++) read_words(a, 1, a % 4, "R4/R2 single word");

    // R5 R6: stream across the top of the array
    read_words(DEPTH - 2, 4, 1, "R5/R6 stream wrap");
    read_words(0, DEPTH + 2, 0, "R6 full circuit");

    // R1: serial activity while deselected is ignored
    for (int k = 0; k < 12; k++) begin
      clk_bit(1'b1);
      chk(do_oe === 1'b0, "R1 idle sk/di ignored", do_oe, 0);
      sk_low();
    end
    read_words(5, 1, 0, "R1 clean read after idle traffic");

    // R7: non-read opcodes leave the output released
    for (int op = 0; op < 4; op++) begin
      if (op == 2) continue;
      select();
      send_cmd(2'(op), 9, 0);
      sk_low();
      for (int b = 0; b < 20; b++) begin
        clk_bit(b[0]);
        chk(do_oe === 1'b0, "R7 non-read opcode", do_oe, 0);
        sk_low();
      end
      deselect();
    end

    // R8: abort a stream mid-word, then a fresh command
    select();
    send_cmd(2'b10, 20, 0);
    sk_low();
    for (int b = 0; b < 5; b++) begin clk_bit(1'b0); sk_low(); end
    cs = 1'b0;
    repeat (6) @(negedge clk);
    chk(do_oe === 1'b0, "R8 abort releases output", do_oe, 0);
    read_words(33, 2, 2, "R8 fresh command after abort");

    // R8: abort inside the command field
    select();
    clk_bit(1'b1); sk_low();
    clk_bit(1'b1); sk_low();
    deselect();
    read_words(40, 1, 0, "R8 fresh after partial command");

    // R9: overwrite a word and read it back
    load(17, 16'h0F0F);
    load(18, 16'hFFFF);
    read_words(17, 2, 0, "R9 reloaded words");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule